// File: doc/BRIEF.md
# SMBus Slave Command Decoder

This block sits behind a bit-level serial engine on an SMBus slave. The engine delivers whole received bytes together with strobes that mark start (including repeated start) and stop conditions. For every byte, the decoder returns an acknowledge decision. It watches the first byte after a start for the device's 7-bit address and the direction bit. It then interprets the write payload that follows.

Two write shapes are understood. The first is a one-byte "set pointer" transaction, which loads a register-RAM address pointer for later reads. The second is a four-byte page-erase frame: a command byte, a high and a low address byte of the nonvolatile store, and a filler byte. A correct page-erase frame produces a one-cycle erase request carrying a 4-bit page index for a separate erase controller. While that controller reports it is busy, the decoder refuses every byte and abandons the transaction.

Top module: `smb_cmd_decoder`

## Requirements
- R1: The first byte after a start is checked against the device address in bits 7:1. A match is acknowledged for both values of bit 0, where 0 means write and 1 means read. A mismatch is refused, and every later byte is refused until the next start.
- R2: A write transaction with exactly one acknowledged payload byte below 80h, closed by a stop, loads that byte into ram_ptr. The new value is visible one cycle after the stop strobe, and ram_ptr changes at no other time.
- R3: A first payload byte of 80h or above, other than the erase command A2h, is refused, and ram_ptr keeps its old value.
- R4: The first payload byte A2h is acknowledged and opens an erase frame. The next byte (the high address byte) is acknowledged only when it is 80h or 81h; any other value is refused, the frame is dropped, and no erase is issued.
- R5: After an accepted high byte, the low byte and one filler byte are acknowledged. A stop then raises erase_req for exactly one cycle, with erase_page = {high byte bit 0, low byte bits 7:5}. Low byte bits 4:0 have no effect.
- R6: An erase frame that a stop or a repeated start ends before the filler byte issues no erase. A repeated start begins a fresh transaction with address decoding.
- R7: While erase_busy is high, every received byte is refused and the transaction is abandoned: it neither loads the pointer nor issues an erase.
- R8: Any byte after a complete send-byte or after a complete erase frame is refused, and that transaction then changes neither the pointer nor issues an erase.
- R9: After reset, ack_out, erase_req, erase_page and ram_ptr are all zero.
- R10: ack_out changes only on the clock edge that samples rx_valid high, and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | One-cycle strobe for a start or repeated start |
| bus_stop | input | 1 | One-cycle strobe for a stop |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | rx_byte holds a new byte this cycle |
| erase_busy | input | 1 | Erase controller is working |
| ack_out | output | 1 | 1 = acknowledge the last byte, 0 = refuse it |
| ram_ptr | output | 7 | Register-RAM address pointer |
| erase_req | output | 1 | One-cycle erase request |
| erase_page | output | 4 | Page index of the last erase request |

## Verification
The bench builds the decoder with its device address overridden to 2Ch, so the write and read address bytes become 58h and59h. This checks that address matching follows the parameter rather than a built-in value. The pointer width, page width, erase command and high-byte base stay at their defaults (7, 4, A2h, 80h). With these values, the 7Fh/80h pointer boundary and both accepted high bytes can be reached directly. The erase page is then a full 4-bit value, so the page index ranges over 0 to 15.

// File: rtl/smb_dec_pkg.sv
package smb_dec_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_HI,
        ST_LO,
        ST_FILL,
        ST_ERASE_RDY,
        ST_SEND1,
        ST_READ,
        ST_SKIP
    } frame_st_e;

    typedef struct packed {
        logic addr_hit;
        logic rw_read;
        logic is_erase_cmd;
        logic ptr_ok;
        logic hi_ok;
    } byte_class_t;

endpackage

// File: rtl/smb_byte_classify.sv
module smb_byte_classify
    import smb_dec_pkg::*;
#(
    parameter int          PTR_W      = 7,
    parameter logic [6:0]  DEV_ADDR   = 7'h5A,
    parameter logic [7:0]  ERASE_CMD  = 8'hA2,
    parameter logic [7:0]  NV_HI_BASE = 8'h80
) (
    input  logic [7:0]  byte_i,
    output byte_class_t cls_o
);

    logic ptr_ok_w;

    generate
        if (PTR_W >= 8) begin : g_ptr_full
            assign ptr_ok_w = 1'b1;
        end else begin : g_ptr_part
            assign ptr_ok_w = (byte_i[7:PTR_W] == '0);
        end
    endgenerate

    always_comb begin
        cls_o.addr_hit     = (byte_i[7:1] == DEV_ADDR);
        cls_o.rw_read      = byte_i[0];
        cls_o.is_erase_cmd = (byte_i == ERASE_CMD);
        cls_o.ptr_ok       = ptr_ok_w;
        cls_o.hi_ok        = (byte_i[7:1] == NV_HI_BASE[7:1]);
    end

endmodule

// File: rtl/smb_frame_fsm.sv
module smb_frame_fsm
    import smb_dec_pkg::*;
#(
    parameter int PTR_W  = 7,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              erase_busy,
    input  byte_class_t       cls,
    output logic              ack_o,
    output logic              ptr_load_o,
    output logic [PTR_W-1:0]  ptr_val_o,
    output logic              erase_fire_o,
    output logic [PAGE_W-1:0] page_o
);

    localparam int LO_BITS = PAGE_W - 1;

    typedef struct packed {
        frame_st_e          st;
        logic               ack;
        logic [PTR_W-1:0]   ptr;
        logic               hi;
        logic [LO_BITS-1:0] lo;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d = q;
        if (bus_start) begin
            d.st = ST_ADDR;
        end else if (bus_stop) begin
            d.st = ST_IDLE;
        end else if (rx_valid) begin
            d.ack = 1'b0;
            if (erase_busy) begin
                if (q.st != ST_IDLE) d.st = ST_SKIP;
            end else begin
                case (q.st)
                    ST_ADDR: begin
                        if (cls.addr_hit) begin
                            d.ack = 1'b1;
                            d.st  = cls.rw_read ? ST_READ : ST_CMD;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                    ST_CMD: begin
                        if (cls.is_erase_cmd) begin
                            d.ack = 1'b1;
                            d.st  = ST_HI;
                        end else if (cls.ptr_ok) begin
                            d.ack = 1'b1;
                            d.ptr = rx_byte[PTR_W-1:0];
                            d.st  = ST_SEND1;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                    ST_HI: begin
                        if (cls.hi_ok) begin
                            d.ack = 1'b1;
                            d.hi  = rx_byte[0];
                            d.st  = ST_LO;
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                    ST_LO: begin
                        d.ack = 1'b1;
                        d.lo  = rx_byte[7 -: LO_BITS];
                        d.st  = ST_FILL;
                    end
                    ST_FILL: begin
                        d.ack = 1'b1;
                        d.st  = ST_ERASE_RDY;
                    end
                    ST_SEND1, ST_ERASE_RDY: begin
                        d.st = ST_SKIP;
                    end
                    default: begin
                        d.st = q.st;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ack: 1'b0, ptr: '0, hi: 1'b0, lo: '0};
        end else begin
            q <= d;
        end
    end

    assign ack_o        = q.ack;
    assign ptr_load_o   = bus_stop && !bus_start && !erase_busy && (q.st == ST_SEND1);
    assign ptr_val_o    = q.ptr;
    assign erase_fire_o = bus_stop && !bus_start && !erase_busy && (q.st == ST_ERASE_RDY);
    assign page_o       = {q.hi, q.lo};

    // R7: a byte seen while the store is busy is always refused
    assert_busy_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && erase_busy && !bus_start && !bus_stop) |=> !ack_o);

    // R10: the decision only moves on a byte
    assert_ack_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(ack_o));

    // R1: once skipping, bytes are refused until a start
    assert_skip_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP && rx_valid && !bus_start && !bus_stop) |=> !ack_o);

    // R4: a refused high byte never leads on to the low byte stage
    assert_hi_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HI && rx_valid && !bus_start && !bus_stop && !cls.hi_ok) |=> (q.st != ST_LO));

endmodule

// File: rtl/smb_cmd_decoder.sv
module smb_cmd_decoder
    import smb_dec_pkg::*;
#(
    parameter int          PTR_W      = 7,
    parameter int          PAGE_W     = 4,
    parameter logic [6:0]  DEV_ADDR   = 7'h5A,
    parameter logic [7:0]  ERASE_CMD  = 8'hA2,
    parameter logic [7:0]  NV_HI_BASE = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    input  logic              erase_busy,
    output logic              ack_out,
    output logic [PTR_W-1:0]  ram_ptr,
    output logic              erase_req,
    output logic [PAGE_W-1:0] erase_page
);

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic              req;
        logic [PAGE_W-1:0] page;
    } out_t;

    byte_class_t       cls_w;
    logic              ptr_load_w;
    logic [PTR_W-1:0]  ptr_val_w;
    logic              fire_w;
    logic [PAGE_W-1:0] page_w;
    out_t              d, q;

    smb_byte_classify #(
        .PTR_W      (PTR_W),
        .DEV_ADDR   (DEV_ADDR),
        .ERASE_CMD  (ERASE_CMD),
        .NV_HI_BASE (NV_HI_BASE)
    ) u_cls (
        .byte_i (rx_byte),
        .cls_o  (cls_w)
    );

    smb_frame_fsm #(
        .PTR_W  (PTR_W),
        .PAGE_W (PAGE_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_start    (bus_start),
        .bus_stop     (bus_stop),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .erase_busy   (erase_busy),
        .cls          (cls_w),
        .ack_o        (ack_out),
        .ptr_load_o   (ptr_load_w),
        .ptr_val_o    (ptr_val_w),
        .erase_fire_o (fire_w),
        .page_o       (page_w)
    );

    always_comb begin
        d     = q;
        d.req = fire_w;
        if (fire_w)     d.page = page_w;
        if (ptr_load_w) d.ptr  = ptr_val_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ram_ptr    = q.ptr;
    assign erase_req  = q.req;
    assign erase_page = q.page;

    // R5: the request is a single-cycle pulse
    assert_erase_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

    // R6: an erase only ever follows a stop
    assert_erase_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(bus_stop));

    // R2: the pointer only moves right after a stop
    assert_ptr_on_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ram_ptr) |-> $past(bus_stop));

    // R5: the page index only moves together with a request
    assert_page_with_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(erase_page) |-> erase_req);

endmodule

// File: tb/sim_smb_cmd_decoder.sv
module sim_smb_cmd_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_valid = 1'b0;
    logic       erase_busy = 1'b0;
    logic       ack_out;
    logic [6:0] ram_ptr;
    logic       erase_req;
    logic [3:0] erase_page;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    smb_cmd_decoder #(.DEV_ADDR(7'h2C)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_start  (bus_start),
        .bus_stop   (bus_stop),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .erase_busy (erase_busy),
        .ack_out    (ack_out),
        .ram_ptr    (ram_ptr),
        .erase_req  (erase_req),
        .erase_page (erase_page)
    );

    // entry: {op[1:0], data[7:0], ack, erase, page[3:0], ptr[6:0]}; op 0=start 1=byte 2=stop
    localparam int NV = 39;
    localparam logic [22:0] VEC [NV] = '{
        {2'd0, 8'h00, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h58, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h35, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd2, 8'h00, 1'b0, 1'b0, 4'h0, 7'h35},
        {2'd0, 8'h00, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h58, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h90, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd2, 8'h00, 1'b0, 1'b0, 4'h0, 7'h35},
        {2'd0, 8'h00, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h58, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'hA2, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h81, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h5F, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h77, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd2, 8'h00, 1'b0, 1'b1, 4'hA, 7'h35},
        {2'd0, 8'h00, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h58, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'hA2, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h82, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h00, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd2, 8'h00, 1'b0, 1'b0, 4'h0, 7'h35},
        {2'd0, 8'h00, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h4A, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h12, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd2, 8'h00, 1'b0, 1'b0, 4'h0, 7'h35},
        {2'd0, 8'h00, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h59, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd2, 8'h00, 1'b0, 1'b0, 4'h0, 7'h35},
        {2'd0, 8'h00, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h58, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h12, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h34, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd2, 8'h00, 1'b0, 1'b0, 4'h0, 7'h35},
        {2'd0, 8'h00, 1'b0, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h58, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'hA2, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'h80, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd1, 8'hE0, 1'b1, 1'b0, 4'h0, 7'h00},
        {2'd2, 8'h00, 1'b0, 1'b0, 4'h0, 7'h35}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] b, input logic exp_ack, input string req);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(req, int'(ack_out), int'(exp_ack));
    endtask

    task automatic do_stop(input logic exp_er, input logic [3:0] exp_pg,
                           input logic [6:0] exp_ptr, input string req);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
        chk(req, int'(erase_req), int'(exp_er));
        if (exp_er) chk(req, int'(erase_page), int'(exp_pg));
        chk(req, int'(ram_ptr), int'(exp_ptr));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 ack", int'(ack_out), 0);
        chk("R9 req", int'(erase_req), 0);
        chk("R9 page", int'(erase_page), 0);
        chk("R9 ptr", int'(ram_ptr), 0);

        // table: R1 R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            v = VEC[i];
            case (v[22:21])
                2'd0: do_start();
                2'd1: do_byte(v[20:13], v[12], $sformatf("R1-R8 vec %0d", i));
                default: do_stop(v[11], v[10:7], v[6:0], $sformatf("R2/R5/R6 vec %0d", i));
            endcase
        end

        // R6: repeated start mid-frame, then a fresh send-byte
        do_start();
        do_byte(8'h58, 1'b1, "R6 addr");
        do_byte(8'hA2, 1'b1, "R6 cmd");
        do_byte(8'h81, 1'b1, "R6 hi");
        do_byte(8'h00, 1'b1, "R6 lo");
        do_start();
        do_byte(8'h58, 1'b1, "R6 readdr");
        do_byte(8'h10, 1'b1, "R6 ptr byte");
        do_stop(1'b0, 4'h0, 7'h10, "R6 no erase after restart");

        // R3 boundary 7Fh accepted
        do_start();
        do_byte(8'h58, 1'b1, "R3 addr");
        do_byte(8'h7F, 1'b1, "R3 7Fh ok");
        do_stop(1'b0, 4'h0, 7'h7F, "R3 ptr 7Fh");

        // R7 busy for whole transaction
        erase_busy = 1'b1;
        do_start();
        do_byte(8'h58, 1'b0, "R7 addr busy");
        do_byte(8'h11, 1'b0, "R7 byte busy");
        do_stop(1'b0, 4'h0, 7'h7F, "R7 ptr kept");
        erase_busy = 1'b0;

        // R7 busy in the middle of an erase frame
        do_start();
        do_byte(8'h58, 1'b1, "R7 addr");
        do_byte(8'hA2, 1'b1, "R7 cmd");
        erase_busy = 1'b1;
        do_byte(8'h81, 1'b0, "R7 hi busy");
        erase_busy = 1'b0;
        do_byte(8'h00, 1'b0, "R7 lo after abandon");
        do_byte(8'h00, 1'b0, "R7 fill after abandon");
        do_stop(1'b0, 4'h0, 7'h7F, "R7 no erase");

        // R5 full frame, low bits ignored, pulse width one
        do_start();
        do_byte(8'h58, 1'b1, "R5 addr");
        do_byte(8'hA2, 1'b1, "R5 cmd");
        do_byte(8'h80, 1'b1, "R5 hi 80h");
        do_byte(8'hFF, 1'b1, "R5 lo");
        do_byte(8'h00, 1'b1, "R5 fill");
        do_stop(1'b1, 4'h7, 7'h7F, "R5 page 7");
        @(negedge clk);
        chk("R5 pulse ends", int'(erase_req), 0);
        chk("R5 page held", int'(erase_page), 7);

        // R8 extra byte after a complete erase frame
        do_start();
        do_byte(8'h58, 1'b1, "R8 addr");
        do_byte(8'hA2, 1'b1, "R8 cmd");
        do_byte(8'h81, 1'b1, "R8 hi");
        do_byte(8'h20, 1'b1, "R8 lo");
        do_byte(8'h00, 1'b1, "R8 fill");
        do_byte(8'h01, 1'b0, "R8 extra byte");
        do_stop(1'b0, 4'h0, 7'h7F, "R8 no erase");

        // R10 hold of the decision
        do_start();
        do_byte(8'h58, 1'b1, "R10 addr");
        repeat (3) @(negedge clk);
        chk("R10 ack held", int'(ack_out), 1);
        do_stop(1'b0, 4'h0, 7'h7F, "R10 stop");
        chk("R10 ack held over stop", int'(ack_out), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule